// File: doc/BRIEF.md
# Two-Stage ALU Result Bypass Datapath

This block is a short integer pipeline with a register file, a pair of staged operand registers, an ALU and a result register. An instruction accepted on a clock edge has its sources read from the register file and captured into the operand stage. One edge later the ALU output is captured into the result register. One edge after that the result is committed to the register file. Because the register file is read before the previous instruction's result has been committed, a dependent instruction that follows directly would otherwise see a stale value.

Two paths close that gap without stalling. The first is a bypass from the result register to both ALU input multiplexers, so the result can feed operand A, operand B, or both. The second applies when an instruction two slots later reads the register being committed in the same cycle: the register file returns the incoming write data for that read.

A tag beside the result register records whether the held value will really be committed. Bypass is allowed only while that tag is set. Operand B can come from an immediate input instead of the register file, and in that case no bypass is applied to it.

The bypass select logic has two named choices per operand. `SRC_STAGED` takes the value captured in the operand stage. `SRC_RESULT` takes the result register.

Top module: `byp_datapath`

## Requirements
- R1: After reset, `res_valid` is 0 and every register reads 0 on the observation port.
- R2: Opcodes are ADD=0, SUB=1 (A minus B), AND=2, OR=3, XOR=4, SLT=5 (signed A<B gives 1, else 0), SLTU=6 (unsigned compare) and NOP=7. NOP never writes. An instruction sampled with `in_valid` high on edge k shows `res_valid`, `res_dst` and `res_data` after edge k+1.
- R3: If an instruction reads as source A the register written by the instruction just before it, it uses that instruction's result.
- R4: If an instruction reads as source B the register written by the instruction just before it, it uses that instruction's result.
- R5: An instruction whose two sources are both the previous instruction's destination gets the previous result on both operands, including in chains of such instructions.
- R6: An instruction reading a register written two slots earlier gets the new value, through write-through on the register file read.
- R7: Register 0 always reads 0. An instruction with destination 0 shows `res_valid` 0, does not change register 0 and is never a bypass source.
- R8: No bypass comes from a slot that does not write: a NOP, or a cycle with `in_valid` low, even when its destination field matches a later source.
- R9: A result shown with `res_valid` high after edge j is visible on the observation port after edge j+1.
- R10: Any mix of dependent instructions, NOPs and idle cycles gives the same results as sequential execution.
- R11: With `in_imm_en` high, operand B equals `in_imm` and `in_src_b` is ignored, even when it matches the previous destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Opcode (R2 encoding) |
| in_dst | input | ADDR_W | Destination register |
| in_src_a | input | ADDR_W | Source register for operand A |
| in_src_b | input | ADDR_W | Source register for operand B |
| in_imm_en | input | 1 | Take operand B from `in_imm` |
| in_imm | input | DATA_W | Immediate operand B |
| obs_addr | input | ADDR_W | Observation read address |
| obs_data | output | DATA_W | Committed contents of `obs_addr` |
| res_valid | output | 1 | Result register will be committed |
| res_dst | output | ADDR_W | Destination held with the result |
| res_data | output | DATA_W | Result register (ALU result) |

## Verification
The bench uses the default widths: 32-bit data and a 32-entry register file. Directed sequences hit each bypass case separately. A long random phase then draws destinations and sources from registers 0 to 7 only, and most sources repeat one of the last two destinations. This packs back-to-back and two-apart collisions, register-0 destinations, NOPs, idle slots and immediate operands densely enough that every select combination comes up many times.

// File: rtl/byp_pkg.sv
package byp_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_SLT  = 3'd5,
        OP_SLTU = 3'd6,
        OP_NOP  = 3'd7
    } alu_op_e;

    typedef enum logic {
        SRC_STAGED = 1'b0,
        SRC_RESULT = 1'b1
    } opnd_src_e;

    localparam int NUM_OPND = 2;

endpackage

// File: rtl/byp_regfile.sv
module byp_regfile #(
    parameter int DATA_W = 32,
    parameter int REG_N  = 32,
    parameter int RD_N   = 2,
    localparam int ADDR_W = $clog2(REG_N)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             waddr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [RD_N-1:0][ADDR_W-1:0]   raddr,
    output logic [RD_N-1:0][DATA_W-1:0]   rdata,
    input  logic [ADDR_W-1:0]             obs_addr,
    output logic [DATA_W-1:0]             obs_data
);

    logic [DATA_W-1:0] mem [REG_N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_N; i++) begin
                mem[i] <= '0;
            end
        end else if (we && (waddr != '0)) begin
            mem[waddr] <= wdata;
        end
    end

    // operand read ports: the write landing this cycle is returned directly
    for (genvar p = 0; p < RD_N; p++) begin : g_rd
        always_comb begin
            if (raddr[p] == '0) begin
                rdata[p] = '0;
            end else if (we && (waddr == raddr[p])) begin
                rdata[p] = wdata;
            end else begin
                rdata[p] = mem[raddr[p]];
            end
        end
    end

    assign obs_data = mem[obs_addr];

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        mem[0] == '0); // R7

    AST_WB_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (waddr != '0)) |=> (mem[$past(waddr)] == $past(wdata))); // R9

endmodule

// File: rtl/byp_select.sv
module byp_select
    import byp_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                              res_we,
    input  logic [ADDR_W-1:0]                 res_dst,
    input  logic [NUM_OPND-1:0][ADDR_W-1:0]   src,
    input  logic [NUM_OPND-1:0]               src_used,
    output opnd_src_e                         sel [NUM_OPND]
);

    logic res_live;

    assign res_live = res_we && (res_dst != '0);

    for (genvar p = 0; p < NUM_OPND; p++) begin : g_sel
        always_comb begin
            if (res_live && src_used[p] && (src[p] == res_dst)) begin
                sel[p] = SRC_RESULT;
            end else begin
                sel[p] = SRC_STAGED;
            end
        end
    end

endmodule

// File: rtl/byp_alu.sv
module byp_alu
    import byp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e            op,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    output logic [DATA_W-1:0]  y
);

    logic lt_s;
    logic lt_u;

    assign lt_s = $signed(a) < $signed(b);
    assign lt_u = a < b;

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SLT:  y = {{(DATA_W-1){1'b0}}, lt_s};
            OP_SLTU: y = {{(DATA_W-1){1'b0}}, lt_u};
            OP_NOP:  y = '0;
        endcase
    end

endmodule

// File: rtl/byp_datapath.sv
module byp_datapath
    import byp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_N  = 32,
    localparam int ADDR_W = $clog2(REG_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [2:0]         in_op,
    input  logic [ADDR_W-1:0]  in_dst,
    input  logic [ADDR_W-1:0]  in_src_a,
    input  logic [ADDR_W-1:0]  in_src_b,
    input  logic               in_imm_en,
    input  logic [DATA_W-1:0]  in_imm,
    input  logic [ADDR_W-1:0]  obs_addr,
    output logic [DATA_W-1:0]  obs_data,
    output logic               res_valid,
    output logic [ADDR_W-1:0]  res_dst,
    output logic [DATA_W-1:0]  res_data
);

    // operand stage
    logic              x_we;
    alu_op_e           x_op;
    logic [ADDR_W-1:0] x_dst;
    logic [ADDR_W-1:0] x_src_a;
    logic [ADDR_W-1:0] x_src_b;
    logic              x_imm_en;
    logic [DATA_W-1:0] x_a;
    logic [DATA_W-1:0] x_b;

    // result stage
    logic              d_we;
    logic [ADDR_W-1:0] d_dst;
    logic [DATA_W-1:0] d_data;

    logic [NUM_OPND-1:0][ADDR_W-1:0] rf_raddr;
    logic [NUM_OPND-1:0][DATA_W-1:0] rf_rdata;
    logic [NUM_OPND-1:0][ADDR_W-1:0] sel_src;
    logic [NUM_OPND-1:0]             sel_used;
    opnd_src_e                       sel [NUM_OPND];

    alu_op_e           in_op_e;
    logic              in_writes;
    logic [DATA_W-1:0] alu_a;
    logic [DATA_W-1:0] alu_b;
    logic [DATA_W-1:0] alu_y;

    assign in_op_e   = alu_op_e'(in_op);
    assign in_writes = in_valid && (in_op_e != OP_NOP) && (in_dst != '0);

    assign rf_raddr[0] = in_src_a;
    assign rf_raddr[1] = in_src_b;

    byp_regfile #(
        .DATA_W (DATA_W),
        .REG_N  (REG_N),
        .RD_N   (NUM_OPND)
    ) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (d_we),
        .waddr    (d_dst),
        .wdata    (d_data),
        .raddr    (rf_raddr),
        .rdata    (rf_rdata),
        .obs_addr (obs_addr),
        .obs_data (obs_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_we     <= 1'b0;
            x_op     <= OP_NOP;
            x_dst    <= '0;
            x_src_a  <= '0;
            x_src_b  <= '0;
            x_imm_en <= 1'b0;
            x_a      <= '0;
            x_b      <= '0;
        end else begin
            x_we     <= in_writes;
            x_op     <= in_op_e;
            x_dst    <= in_dst;
            x_src_a  <= in_src_a;
            x_src_b  <= in_src_b;
            x_imm_en <= in_imm_en;
            x_a      <= rf_rdata[0];
            x_b      <= in_imm_en ? in_imm : rf_rdata[1];
        end
    end

    assign sel_src[0]  = x_src_a;
    assign sel_src[1]  = x_src_b;
    assign sel_used[0] = 1'b1;
    assign sel_used[1] = !x_imm_en;

    byp_select #(
        .ADDR_W (ADDR_W)
    ) u_sel (
        .res_we   (d_we),
        .res_dst  (d_dst),
        .src      (sel_src),
        .src_used (sel_used),
        .sel      (sel)
    );

    always_comb begin
        unique case (sel[0])
            SRC_RESULT: alu_a = d_data;
            SRC_STAGED: alu_a = x_a;
        endcase
        unique case (sel[1])
            SRC_RESULT: alu_b = d_data;
            SRC_STAGED: alu_b = x_b;
        endcase
    end

    byp_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op (x_op),
        .a  (alu_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_we   <= 1'b0;
            d_dst  <= '0;
            d_data <= '0;
        end else begin
            d_we   <= x_we;
            d_dst  <= x_dst;
            d_data <= alu_y;
        end
    end

    assign res_valid = d_we;
    assign res_dst   = d_dst;
    assign res_data  = d_data;

    AST_FWD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (d_we && (d_dst != '0) && (d_dst == x_src_a)) |-> (alu_a == d_data)); // R3

    AST_FWD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (d_we && (d_dst != '0) && (d_dst == x_src_b) && !x_imm_en) |-> (alu_b == d_data)); // R4

    AST_IMM_B: assert property (@(posedge clk) disable iff (!rst_n)
        x_imm_en |-> (alu_b == x_b)); // R11

    AST_FWD_NEEDS_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel[0] == SRC_RESULT) || (sel[1] == SRC_RESULT)) |-> d_we); // R8

    AST_NO_R0_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_dst != '0)); // R7

endmodule

// File: tb/byp_datapath_tb_top.sv
`timescale 1ns/1ps
module byp_datapath_tb_top;

    localparam int DW = 32;
    localparam int RN = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [2:0]    in_op;
    logic [AW-1:0] in_dst, in_src_a, in_src_b;
    logic          in_imm_en;
    logic [DW-1:0] in_imm;
    logic [AW-1:0] obs_addr = '0;
    logic [DW-1:0] obs_data;
    logic          res_valid;
    logic [AW-1:0] res_dst;
    logic [DW-1:0] res_data;

    byp_datapath #(.DATA_W(DW), .REG_N(RN)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_imm_en(in_imm_en), .in_imm(in_imm), .obs_addr(obs_addr),
        .obs_data(obs_data), .res_valid(res_valid), .res_dst(res_dst),
        .res_data(res_data)
    );

    always #2 clk = ~clk;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    // sequential model and a delayed copy matching commit timing
    logic [DW-1:0] seq_m  [RN];
    logic [DW-1:0] arch_m [RN];
    logic          e1_we, e2_we;
    logic [AW-1:0] e1_dst, e2_dst;
    logic [DW-1:0] e1_data, e2_data;

    function automatic logic [DW-1:0] ref_alu(int op, logic [DW-1:0] a, logic [DW-1:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return ($signed(a) < $signed(b)) ? 1 : 0;
            6: return (a < b) ? 1 : 0;
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RN; i++) begin
                seq_m[i]  = '0;
                arch_m[i] = '0;
            end
            e1_we = 1'b0; e2_we = 1'b0;
            e1_dst = '0; e2_dst = '0; e1_data = '0; e2_data = '0;
        end else begin
            logic [DW-1:0] a, b, r;
            logic w;
            if (e2_we) arch_m[e2_dst] = e2_data;
            e2_we = e1_we; e2_dst = e1_dst; e2_data = e1_data;
            if (in_valid) begin
                a = seq_m[in_src_a];
                b = in_imm_en ? in_imm : seq_m[in_src_b];
                r = ref_alu(int'(in_op), a, b);
                w = (in_op != 3'd7) && (in_dst != '0);
                if (w) seq_m[in_dst] = r;
                e1_we = w; e1_dst = in_dst; e1_data = r;
            end else begin
                e1_we = 1'b0;
            end
        end
    end

    task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            chk(cur_tag, "res_valid", DW'(res_valid), DW'(e2_we));
            if (e2_we) begin
                chk(cur_tag, "res_dst", DW'(res_dst), DW'(e2_dst));
                chk(cur_tag, "res_data", res_data, e2_data);
            end
            chk((cur_tag == "R1") ? "R1" : "R9", "obs_data", obs_data, arch_m[obs_addr]);
            obs_addr = obs_addr + 1'b1;
        end
    end

    task automatic issue(bit v, int op, int d, int sa, int sb, bit ie = 1'b0, logic [DW-1:0] imm = '0);
        @(negedge clk);
        in_valid  = v;
        in_op     = op[2:0];
        in_dst    = d[AW-1:0];
        in_src_a  = sa[AW-1:0];
        in_src_b  = sb[AW-1:0];
        in_imm_en = ie;
        in_imm    = imm;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) issue(1'b0, 7, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0; in_op = 3'd7; in_dst = '0; in_src_a = '0;
        in_src_b = '0; in_imm_en = 1'b0; in_imm = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        cur_tag = "R1";
        idle(34);

        // R2: each opcode on independent operands
        cur_tag = "R2";
        issue(1, 0, 1, 0, 0, 1, 32'd7);
        issue(1, 0, 2, 0, 0, 1, 32'hFFFF_FFFD);
        idle(2);
        issue(1, 1, 3, 1, 2);
        issue(1, 2, 4, 1, 2);
        issue(1, 3, 5, 1, 2);
        issue(1, 4, 6, 1, 2);
        issue(1, 5, 8, 2, 1);
        issue(1, 6, 9, 2, 1);
        issue(1, 7, 7, 1, 2);
        idle(3);

        // R3: source A from the previous result
        cur_tag = "R3";
        issue(1, 0, 10, 0, 0, 1, 32'h100);
        issue(1, 0, 11, 10, 0, 1, 32'h1);
        idle(3);

        // R4: source B from the previous result
        cur_tag = "R4";
        issue(1, 0, 12, 0, 0, 1, 32'h20);
        issue(1, 1, 13, 1, 12);
        idle(3);

        // R5: both sources from the previous result, chained
        cur_tag = "R5";
        issue(1, 0, 14, 0, 0, 1, 32'd9);
        issue(1, 0, 14, 14, 14);
        issue(1, 0, 14, 14, 14);
        idle(3);

        // R6: value written two slots earlier
        cur_tag = "R6";
        issue(1, 0, 15, 0, 0, 1, 32'h55);
        issue(1, 0, 16, 0, 0, 1, 32'h1);
        issue(1, 3, 17, 15, 0);
        issue(1, 0, 18, 0, 16);
        idle(3);

        // R7: destination 0 is dropped and never bypassed
        cur_tag = "R7";
        issue(1, 0, 0, 0, 0, 1, 32'h77);
        issue(1, 0, 20, 0, 0);
        issue(1, 3, 19, 1, 0);
        idle(3);

        // R8: NOP and idle slot with a matching destination field
        cur_tag = "R8";
        issue(1, 0, 21, 0, 0, 1, 32'h33);
        idle(2);
        issue(1, 7, 21, 1, 0, 1, 32'h5);
        issue(1, 0, 22, 21, 0, 1, 32'h0);
        issue(0, 0, 21, 1, 0, 1, 32'h9);
        issue(1, 0, 23, 0, 21);
        idle(3);

        // R11: immediate operand B ignores a matching source B field
        cur_tag = "R11";
        issue(1, 0, 25, 0, 0, 1, 32'hABC);
        issue(1, 0, 26, 1, 25, 1, 32'h10);
        idle(3);

        // R10: random dependent sequences against the sequential model
        cur_tag = "R10";
        begin
            int last1 = 1;
            int last2 = 2;
            for (int n = 0; n < 3000; n++) begin
                int sa, sb, d, pick;
                pick = $urandom_range(0, 9);
                sa = (pick < 4) ? last1 : (pick < 6) ? last2 : $urandom_range(0, 7);
                pick = $urandom_range(0, 9);
                sb = (pick < 4) ? last1 : (pick < 6) ? last2 : $urandom_range(0, 7);
                d  = $urandom_range(0, 7);
                issue($urandom_range(0, 9) != 0, $urandom_range(0, 7), d, sa, sb,
                      $urandom_range(0, 3) == 0, $urandom);
                last2 = last1;
                last1 = d;
            end
        end
        idle(4);
        done = 1'b1;
        finish_run();
    end

endmodule